// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and a calendar date in packed BCD registers: seconds, minutes, hours, day of month, month, two-digit year and a day-of-week index. A faster enable pulse, `subTick`, comes from an external prescaler. Every `TICKS_PER_SEC`-th pulse advances the time by one second. Carries ripple through the fields in the same cycle. The day-of-month rollover takes account of month length and of leap years. The hour field runs in either a 24-hour or a 12-hour AM/PM format.

A host loads and reads the registers through a single-cycle register port. Loads of the time fields are accepted only while a write-enable bit in the status register is set. Reset models a total loss of power. It raises a failure flag and freezes the counters until the host performs its first accepted time load. Every accepted time load restarts the sub-second phase. Each read burst works from a snapshot of all seven fields taken in its first cycle, so a carry that lands during the burst cannot tear the value being read.

Top module: `bcd_calendar`

## Requirements
- R1: Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 status. Reads of addresses above 7 return 00h. After reset the time fields hold 00, 00, 12h (12 AM, 12-hour mode), 01, 01, 00, 0, and status reads 01h.
- R2: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R3: With hour bit 7 = 1 (24-hour mode), bits 5:0 count BCD 00 to 23. The step from 23 to 00 advances the date.
- R4: With hour bit 7 = 0 (12-hour mode), bits 4:0 hold BCD 1 to 12 and bit 5 is 1 for PM. The hour runs 12, 1, ..., 11. Bit 5 toggles on the step from 11 to 12. The date advances when 11 PM becomes 12 AM.
- R5: Months 04, 06, 09 and 11 end after day 30, and February ends according to R6. All other months end after day 31. After its last day a month rolls to day 01 of the next month.
- R6: February has a day 29 exactly when the year value is divisible by 4, year 00 included. Month 12 rolls to 01 and advances the year, and year 99 rolls to 00.
- R7: The day of week counts 0 to 6 and wraps to 0. It advances whenever the date advances.
- R8: Writes to addresses 0 to 6 take effect only while status bit 4 (write enable) is 1. A write to address 7 sets bit 4, and status bit 0 ignores host writes.
- R9: After reset, status bit 0 (failure flag) is 1 and no field advances. The first accepted time write clears the flag and lets counting start.
- R10: Outside R9, one second elapses on every `TICKS_PER_SEC`-th `subTick`. An accepted time write restarts the phase, so the next increment follows exactly `TICKS_PER_SEC` further pulses.
- R11: `rdata` is registered and valid one cycle after `rdEn` rises. A read burst (`rdEn` held high) returns time fields from a snapshot taken in its first cycle, even if the time advances during the burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, models total power loss |
| subTick | input | 1 | Sub-second enable pulse from the prescaler |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Read request, held high for a burst |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the request |

## Verification
The range assertions take for granted that the host only loads legal BCD values. That means seconds and minutes 00 to 59, a valid hour for the selected format, a date that exists in the loaded month, and a month of 01 to 12. Every load the stimulus issues comes from a decimal value converted to BCD inside these ranges, so the counters never leave their legal codes. The stimulus also never asserts `wrEn` and `rdEn` in the same cycle. It never lets a `subTick` coincide with a write, so the write-precedence rule is not what the checks depend on.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 4;
  localparam int NUM_TIME    = 7;
  localparam int STATUS_ADDR = 7;
  localparam int WE_BIT      = 4;
  localparam int FAIL_BIT    = 0;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DATE = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;
  localparam int IDX_DOW  = 6;

  typedef struct packed {
    logic secStep;
    logic timeWrite;
    logic snapLoad;
    logic readSnap;
  } ctrlStrobes_t;

  function automatic logic [REG_W-1:0] bcdInc(input logic [REG_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic yearIsLeap(input logic [REG_W-1:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [REG_W-1:0] monthLast(input logic [REG_W-1:0] mon,
                                                 input logic [REG_W-1:0] yr);
    case (mon)
      8'h02:                      return yearIsLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] regDefault(input int idx);
    case (idx)
      IDX_HOUR:          return 8'h12;
      IDX_DATE, IDX_MON: return 8'h01;
      default:           return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcdcal_ctrl.sv
module bcdcal_ctrl
  import bcdcal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              subTick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              weData,
  output ctrlStrobes_t      strobes,
  output logic              failFlag,
  output logic              weBit
);
  localparam int PH_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);

  logic [PH_W-1:0] phase;
  logic            rdEnQ;
  logic            timeAddr;
  logic            statusWrite;
  logic            lastPhase;

  always_comb begin
    timeAddr           = addr < ADDR_W'(NUM_TIME);
    statusWrite        = wrEn && (addr == ADDR_W'(STATUS_ADDR));
    lastPhase          = phase == PH_LAST;
    strobes.timeWrite  = wrEn && timeAddr && weBit;
    strobes.secStep    = subTick && lastPhase && !failFlag && !strobes.timeWrite;
    strobes.snapLoad   = rdEn && !rdEnQ;
    strobes.readSnap   = rdEn && rdEnQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      failFlag <= 1'b1;
      weBit    <= 1'b0;
      rdEnQ    <= 1'b0;
    end else begin
      rdEnQ <= rdEn;
      if (statusWrite) weBit <= weData;
      if (strobes.timeWrite) begin
        failFlag <= 1'b0;
        phase    <= '0;
      end else if (subTick && !failFlag) begin
        phase <= lastPhase ? '0 : phase + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/bcdcal_dp.sv
module bcdcal_dp
  import bcdcal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  statusByte,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  secVal,
  output logic [REG_W-1:0]  minVal,
  output logic [REG_W-1:0]  hourVal,
  output logic [REG_W-1:0]  dateVal,
  output logic [REG_W-1:0]  monVal
);
  logic [REG_W-1:0] live [NUM_TIME];
  logic [REG_W-1:0] snap [NUM_TIME];
  logic [REG_W-1:0] nxt  [NUM_TIME];
  logic             secWrap, minWrap, dayCarry, monWrap, yearWrap;
  logic [REG_W-1:0] lastDay, hrInc, liveSel, snapSel, otherSel;
  logic             isTime;

  always_comb begin
    secWrap      = live[IDX_SEC] == 8'h59;
    nxt[IDX_SEC] = secWrap ? '0 : bcdInc(live[IDX_SEC]);

    minWrap      = secWrap && (live[IDX_MIN] == 8'h59);
    nxt[IDX_MIN] = !secWrap ? live[IDX_MIN] : (minWrap ? '0 : bcdInc(live[IDX_MIN]));

    dayCarry      = 1'b0;
    nxt[IDX_HOUR] = live[IDX_HOUR];
    if (live[IDX_HOUR][7]) hrInc = bcdInc({2'b00, live[IDX_HOUR][5:0]});
    else                   hrInc = bcdInc({3'b000, live[IDX_HOUR][4:0]});
    if (minWrap) begin
      if (live[IDX_HOUR][7]) begin
        if (live[IDX_HOUR][5:0] == 6'h23) begin
          nxt[IDX_HOUR] = 8'h80;
          dayCarry      = 1'b1;
        end else begin
          nxt[IDX_HOUR] = {2'b10, hrInc[5:0]};
        end
      end else begin
        if (live[IDX_HOUR][4:0] == 5'h12) begin
          nxt[IDX_HOUR] = {2'b00, live[IDX_HOUR][5], 5'h01};
        end else if (live[IDX_HOUR][4:0] == 5'h11) begin
          nxt[IDX_HOUR] = {2'b00, ~live[IDX_HOUR][5], 5'h12};
          dayCarry      = live[IDX_HOUR][5];
        end else begin
          nxt[IDX_HOUR] = {2'b00, live[IDX_HOUR][5], hrInc[4:0]};
        end
      end
    end

    lastDay       = monthLast(live[IDX_MON], live[IDX_YEAR]);
    monWrap       = dayCarry && (live[IDX_DATE] == lastDay);
    nxt[IDX_DATE] = !dayCarry ? live[IDX_DATE] : (monWrap ? 8'h01 : bcdInc(live[IDX_DATE]));

    yearWrap      = monWrap && (live[IDX_MON] == 8'h12);
    nxt[IDX_MON]  = !monWrap ? live[IDX_MON] : (yearWrap ? 8'h01 : bcdInc(live[IDX_MON]));
    nxt[IDX_YEAR] = !yearWrap ? live[IDX_YEAR]
                  : ((live[IDX_YEAR] == 8'h99) ? 8'h00 : bcdInc(live[IDX_YEAR]));
    nxt[IDX_DOW]  = !dayCarry ? live[IDX_DOW]
                  : ((live[IDX_DOW][2:0] == 3'd6) ? 8'h00 : {5'd0, live[IDX_DOW][2:0] + 3'd1});
  end

  always_comb begin
    liveSel  = '0;
    snapSel  = '0;
    isTime   = addr < ADDR_W'(NUM_TIME);
    otherSel = (addr == ADDR_W'(STATUS_ADDR)) ? statusByte : '0;
    for (int i = 0; i < NUM_TIME; i++) begin
      if (addr == ADDR_W'(i)) begin
        liveSel = live[i];
        snapSel = snap[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TIME; i++) begin
        live[i] <= regDefault(i);
        snap[i] <= '0;
      end
      rdata <= '0;
    end else begin
      for (int i = 0; i < NUM_TIME; i++) begin
        if (strobes.timeWrite && (addr == ADDR_W'(i))) live[i] <= wdata;
        else if (strobes.secStep)                      live[i] <= nxt[i];
        if (strobes.snapLoad) snap[i] <= live[i];
      end
      if (strobes.snapLoad)      rdata <= isTime ? liveSel : otherSel;
      else if (strobes.readSnap) rdata <= isTime ? snapSel : otherSel;
    end
  end

  assign secVal  = live[IDX_SEC];
  assign minVal  = live[IDX_MIN];
  assign hourVal = live[IDX_HOUR];
  assign dateVal = live[IDX_DATE];
  assign monVal  = live[IDX_MON];
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcdcal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              subTick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata
);
  ctrlStrobes_t     strobes;
  logic             failFlag, weBit;
  logic [REG_W-1:0] statusByte;
  logic [REG_W-1:0] secVal, minVal, hourVal, dateVal, monVal;

  always_comb begin
    statusByte           = '0;
    statusByte[WE_BIT]   = weBit;
    statusByte[FAIL_BIT] = failFlag;
  end

  bcdcal_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .subTick(subTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .weData(wdata[WE_BIT]), .strobes(strobes),
    .failFlag(failFlag), .weBit(weBit)
  );

  bcdcal_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .wdata(wdata),
    .statusByte(statusByte), .rdata(rdata), .secVal(secVal), .minVal(minVal),
    .hourVal(hourVal), .dateVal(dateVal), .monVal(monVal)
  );
endmodule

// File: rtl/bcdcal_chk.sv
module bcdcal_chk
  import bcdcal_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [REG_W-1:0]  secVal,
  input logic [REG_W-1:0]  minVal,
  input logic [REG_W-1:0]  hourVal,
  input logic [REG_W-1:0]  dateVal,
  input logic [REG_W-1:0]  monVal,
  input logic              failFlag,
  input logic              weBit
);
  // R2
  sec_bcd_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secVal[3:0] <= 4'd9) && (secVal <= 8'h59));

  // R3
  hour24_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    hourVal[7] |-> (hourVal[5:0] <= 6'h23) && (hourVal[3:0] <= 4'd9));

  // R4
  hour12_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hourVal[7] |-> (hourVal[4:0] != 5'h00) && (hourVal[4:0] <= 5'h12));

  // R5
  date_month_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dateVal != 8'h00) && (dateVal <= 8'h31) && (monVal != 8'h00) && (monVal <= 8'h12));

  // R8
  locked_flag_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weBit |=> $stable(failFlag));

  // R8
  sec_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (addr == ADDR_W'(IDX_SEC)) && weBit |=> secVal == $past(wdata));

  // R9
  frozen_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    failFlag && !weBit |=> $stable(secVal) && $stable(minVal) && $stable(hourVal));

  // R9
  flag_stays_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !failFlag |=> !failFlag);
endmodule

bind bcd_calendar bcdcal_chk u_chk (.*);

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       subTick = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rstN(rstN), .subTick(subTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] hourCode(input int h, input bit mode24);
    int h12;
    if (mode24) return 8'h80 | toBcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return ((h >= 12) ? 8'h20 : 8'h00) | toBcd(h12);
  endfunction

  function automatic int daysIn(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = 4'(a);
    @(negedge clk);
    v = rdata;
    rdEn = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); subTick = 1'b1;
      @(negedge clk); subTick = 1'b0;
    end
  endtask

  task automatic setAll(input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                        input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr,
                        input logic [7:0] dw);
    wr(0, se); wr(1, mi); wr(2, hr); wr(3, dt); wr(4, mo); wr(5, yr); wr(6, dw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] defs [7];
    defs = '{8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00};
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset values and address map
    for (int i = 0; i < 7; i++) begin
      rd(i, v); chk($sformatf("R1 reg %0d", i), v, defs[i]);
    end
    rd(7, v);  chk("R1 status", v, 8'h01);
    rd(11, v); chk("R1 unmapped", v, 8'h00);

    // R9 frozen after power loss
    tick(TPS * 3);
    rd(0, v); chk("R9 frozen seconds", v, 8'h00);

    // R8 write ignored while locked
    wr(0, 8'h30);
    rd(0, v); chk("R8 locked write", v, 8'h00);
    rd(7, v); chk("R8 flag kept", v, 8'h01);
    wr(7, 8'h10);
    rd(7, v); chk("R8 enable bit", v, 8'h11);

    // R9 first write clears flag, counting starts
    wr(0, 8'h30);
    rd(7, v); chk("R9 flag cleared", v, 8'h10);
    tick(TPS);
    rd(0, v); chk("R9 counting", v, 8'h31);

    // R10 phase restart on write
    tick(2);
    wr(0, 8'h40);
    tick(TPS - 1);
    rd(0, v); chk("R10 no early step", v, 8'h40);
    tick(1);
    rd(0, v); chk("R10 step after full second", v, 8'h41);

    // R8 failure bit ignores host writes
    wr(7, 8'h11);
    rd(7, v); chk("R8 flag read-only", v, 8'h10);

    // R2 seconds sweep
    for (int s = 0; s < 60; s++) begin
      wr(0, toBcd(s)); wr(1, 8'h05);
      tick(TPS);
      rd(0, v); chk("R2 seconds", v, toBcd((s + 1) % 60));
      rd(1, v); chk("R2 sec carry", v, (s == 59) ? 8'h06 : 8'h05);
    end

    // R2 minutes sweep
    for (int m = 0; m < 60; m++) begin
      wr(0, 8'h59); wr(1, toBcd(m)); wr(2, 8'h90);
      tick(TPS);
      rd(1, v); chk("R2 minutes", v, toBcd((m + 1) % 60));
      rd(2, v); chk("R2 min carry", v, (m == 59) ? 8'h91 : 8'h90);
    end

    // R3 / R4 hour sweeps in both formats
    for (int md = 0; md < 2; md++) begin
      for (int h = 0; h < 24; h++) begin
        setAll(hourCode(h, md == 1), 8'h59, 8'h59, 8'h10, 8'h05, 8'h07, 8'h02);
        tick(TPS);
        rd(2, v);
        chk(md == 1 ? "R3 hour 24h" : "R4 hour 12h", v, hourCode((h + 1) % 24, md == 1));
        rd(3, v);
        chk(md == 1 ? "R3 day carry" : "R4 day carry", v, (h == 23) ? 8'h11 : 8'h10);
      end
    end

    // R5 R6 R7 calendar sweep over a leap cycle and year 99
    for (int k = 0; k < 5; k++) begin
      int y;
      y = (k == 4) ? 99 : k;
      for (int m = 1; m <= 12; m++) begin
        for (int d = 1; d <= daysIn(m, y); d++) begin
          int ed, em, ey;
          ed = (d == daysIn(m, y)) ? 1 : d + 1;
          em = (ed == 1) ? (m % 12) + 1 : m;
          ey = (ed == 1 && m == 12) ? (y + 1) % 100 : y;
          setAll(8'hA3, 8'h59, 8'h59, toBcd(d), toBcd(m), toBcd(y), toBcd(d % 7));
          tick(TPS);
          rd(3, v); chk("R5 date", v, toBcd(ed));
          rd(4, v); chk("R5 month", v, toBcd(em));
          rd(5, v); chk("R6 year", v, toBcd(ey));
          rd(6, v); chk("R7 weekday", v, toBcd((d + 1) % 7));
        end
      end
    end

    // R11 snapshot held across a carry during a read burst
    setAll(8'h90, 8'h05, 8'h59, 8'h10, 8'h05, 8'h07, 8'h02);
    @(negedge clk); rdEn = 1'b1; addr = 4'd0;
    @(negedge clk); chk("R11 first beat", rdata, 8'h59);
    tick(TPS);
    @(negedge clk); addr = 4'd1;
    @(negedge clk); chk("R11 snapshot minutes", rdata, 8'h05);
    addr = 4'd0;
    @(negedge clk); chk("R11 snapshot seconds", rdata, 8'h59);
    rdEn = 1'b0;
    rd(1, v); chk("R11 fresh minutes", v, 8'h06);
    rd(0, v); chk("R11 fresh seconds", v, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule